// File: doc/BRIEF.md
# Periodic Wakeup Down-Counter

This block is the periodic wakeup timer of a real-time clock. A binary down-counter is loaded from a programmable reload register. It counts ticks from a selectable source and produces a wakeup event each time a tick finds it at zero. After each event it reloads by itself and keeps running, so software programs the period once and then receives a steady series of events. Each event raises a one-cycle interrupt pulse and sets a sticky flag that stays set until it is explicitly cleared.

The tick source sets the resolution. There are two kinds of source. The first is the raw low-speed clock, divided by 2, 4, 8 or 16; it is synchronised inside the block and counted on its rising edges. The second is a 1 Hz calendar tick. The 1 Hz source has an optional range extension that adds 2^16 to every period. With a 32.768 kHz low-speed clock, the fastest setting gives an event about every 61 µs, and the slowest gives about 36 hours.

The reload value and the tick-source code are written together through a single write strobe. The write takes effect only while the timer is disabled. Enabling the timer starts it from the programmed reload value with the divider cleared.

Top module: `rtc_wakeup_timer`

## Requirements
- R1: After reset, wake_flag and wake_irq are both 0.
- R2: A cfg_we write stores cfg_reload and cfg_sel only when enable is 0. While enable is 1, a write is ignored and the running period does not change.
- R3: The cfg_sel codes 3'b000, 3'b001, 3'b010 and 3'b011 select the low-speed clock divided by 16, 8, 4 and 2 respectively. A tick occurs on every D-th synchronised rising edge of lsclk_raw, counted from the moment of enabling.
- R4: With reload value N, the counter counts down once per tick from N. The tick that finds it at zero is an expiry and reloads it with N. The period is therefore N+1 ticks.
- R5: Every expiry gives exactly one single-cycle pulse on wake_irq. Counting continues without software action, so expiries repeat indefinitely.
- R6: wake_flag is set by each expiry and stays set until flag_clr. If a clear and an expiry occur in the same cycle, the flag ends up set.
- R7: The cfg_sel codes 3'b100 and 3'b101 use sec_tick as the tick. In these modes, edges of lsclk_raw have no effect.
- R8: The cfg_sel codes 3'b110 and 3'b111 use sec_tick and add 2^16 to the load value, which gives a period of N+1+65536 ticks.
- R9: While enable is 0, no expiry occurs. Re-enabling restarts both the divider and the counter from the stored reload value, discarding any partial count.
- R10: A reload value of 0 with the divide-by-2 source gives one expiry every two low-speed clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lsclk_raw | input | 1 | Raw low-speed clock, asynchronous to clk |
| sec_tick | input | 1 | 1 Hz calendar tick, one clk-cycle pulse per tick |
| enable | input | 1 | Timer run enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_reload | input | 16 | Reload value N |
| cfg_sel | input | 3 | Tick-source code |
| flag_clr | input | 1 | Clears wake_flag |
| wake_flag | output | 1 | Sticky wakeup flag |
| wake_irq | output | 1 | One-cycle pulse per expiry |

## Verification
The hardest case to reach is the range-extended mode: an expiry there needs more than 65,536 ticks. The stimulus gets there by holding sec_tick high for 65,536 consecutive clk cycles, which the block takes as one tick per cycle. It then checks that no event has occurred, and checks that the single following tick produces exactly one. The low-speed modes are swept over every divider and the first six reload values. The event count is compared after every individual low-speed edge, so an off-by-one in the divider phase or in the reload shows up at the edge where it occurs.

// File: rtl/rtc_wut_pkg.sv
// Package: shared definitions for the periodic wakeup timer.
// The tick-source code is 3 bits wide. Bit 2 selects the 1 Hz tick.
// When bit 2 is set, bit 1 requests the 2^16 range extension.
// When bit 2 is clear, bits 1:0 pick the divider stage.
package rtc_wut_pkg;

    localparam int SEL_W = 3;

    typedef logic [SEL_W-1:0] wut_sel_t;

    // True when the code selects the 1 Hz calendar tick
    function automatic logic wut_is_sec(input wut_sel_t sel);
        return sel[2];
    endfunction

    // True when the code asks for the extra 2^16 of range
    function automatic logic wut_is_ext(input wut_sel_t sel);
        return sel[2] & sel[1];
    endfunction

    // Divider stage code for the low-speed modes (0 means the largest divide)
    function automatic logic [1:0] wut_stage(input wut_sel_t sel);
        return sel[1:0];
    endfunction

endpackage

// File: rtl/wut_edge_sync.sv
// Module: wut_edge_sync
// Brings the raw low-speed clock into the clk domain through a synchroniser
// chain and emits a one-cycle pulse on each rising edge.
// Assumes: the raw clock is far slower than clk, so each level is held for
// several clk cycles.
module wut_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic rise
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    // Shift the raw level through the chain; the last stage keeps the previous level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], raw_in};
        end
    end

    // A rising edge is a synchronised high paired with a low one stage later
    always_comb begin
        rise = chain_q[STAGES-1] & ~chain_q[STAGES];
    end

    // R3
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/wut_tick_source.sv
// Module: wut_tick_source
// Produces the counter's tick. In the low-speed modes, a prescaler counts
// synchronised edges and fires on every 2^k-th edge. In the 1 Hz modes, the
// calendar tick passes straight through.
// Assumes: the select code is stable while run is high, and the prescaler
// restarts whenever run is low.
module wut_tick_source
    import rtc_wut_pkg::*;
#(
    parameter int PRE_W = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  wut_sel_t sel,
    input  logic     ls_rise,
    input  logic     sec_tick,
    output logic     tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;
    logic             ls_tick;

    // Build the low-bit mask; a divide by 2^(PRE_W-stage) needs PRE_W-stage ones
    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i < (PRE_W - int'(wut_stage(sel))));
        end
    end

    // Count low-speed edges while running; hold at zero while stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run) begin
            pre_q <= '0;
        end else if (ls_rise) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // Fire on the edge that completes a full group of masked bits
    always_comb begin
        ls_tick = ls_rise & ((pre_q & mask) == mask);
    end

    // Pick the tick source according to the select code
    always_comb begin
        if (!run) begin
            tick = 1'b0;
        end else if (wut_is_sec(sel)) begin
            tick = sec_tick;
        end else begin
            tick = ls_tick;
        end
    end

    // R9
    pre_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pre_q == '0));

    // R3
    tick_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (ls_rise || sec_tick));

    // R7
    sec_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wut_is_sec(sel) && !sec_tick) |-> !tick);

endmodule

// File: rtl/wut_counter.sv
// Module: wut_counter
// The reload down-counter. It is one bit wider than the reload value so that
// the range extension can add 2^16. While stopped it follows the load value,
// so enabling starts from a fresh reload.
// Assumes: load_val is stable while run is high.
module wut_counter #(
    parameter int CNT_W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic [CNT_W:0] load_val,
    output logic         hit
);
    logic [CNT_W:0] cnt_q;

    // Expiry: a tick arriving while the count already sits at zero
    always_comb begin
        hit = run & tick & (cnt_q == '0);
    end

    // Follow the load while stopped; on each tick, count down or reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= load_val;
        end else if (tick) begin
            if (cnt_q == '0) begin
                cnt_q <= load_val;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R5
    auto_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cnt_q == $past(load_val)));

    // R4
    bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> (cnt_q <= load_val));

endmodule

// File: rtl/rtc_wakeup_timer.sv
// Module: rtc_wakeup_timer (top)
// Periodic wakeup timer. It holds the configuration registers, which are
// writable only while disabled, and produces the sticky flag and the
// interrupt pulse from the counter's expiry.
// Assumes: sec_tick is a single-cycle pulse synchronous to clk, and
// lsclk_raw is slow relative to clk.
module rtc_wakeup_timer
    import rtc_wut_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PRE_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lsclk_raw,
    input  logic             sec_tick,
    input  logic             enable,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_reload,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic             flag_clr,
    output logic             wake_flag,
    output logic             wake_irq
);
    logic [CNT_W-1:0] reload_q;
    wut_sel_t         sel_q;
    logic             cfg_take;
    logic [CNT_W:0]   load_val;
    logic             ls_rise;
    logic             tick;
    logic             hit;

    // Accept configuration only while the timer is stopped
    always_comb begin
        cfg_take = cfg_we & ~enable;
    end

    // Configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            sel_q    <= '0;
        end else if (cfg_take) begin
            reload_q <= cfg_reload;
            sel_q    <= cfg_sel;
        end
    end

    // Present the incoming write at once, so a write just before enable is the one loaded
    always_comb begin
        if (cfg_take) begin
            load_val = {wut_is_ext(cfg_sel), cfg_reload};
        end else begin
            load_val = {wut_is_ext(sel_q), reload_q};
        end
    end

    wut_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (lsclk_raw),
        .rise   (ls_rise)
    );

    wut_tick_source #(.PRE_W(PRE_W)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (enable),
        .sel      (sel_q),
        .ls_rise  (ls_rise),
        .sec_tick (sec_tick),
        .tick     (tick)
    );

    wut_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (enable),
        .tick     (tick),
        .load_val (load_val),
        .hit      (hit)
    );

    // Register the interrupt pulse and the sticky flag; an expiry wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_irq  <= 1'b0;
            wake_flag <= 1'b0;
        end else begin
            wake_irq <= hit;
            if (hit) begin
                wake_flag <= 1'b1;
            end else if (flag_clr) begin
                wake_flag <= 1'b0;
            end
        end
    end

    // R6
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |-> wake_flag);

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> (!wake_flag || wake_irq));

    // R9
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !wake_irq);

    // R2
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> ($stable(reload_q) && $stable(sel_q)));

endmodule

// File: tb/rtc_wakeup_timer_test.sv
module rtc_wakeup_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lsclk_raw = 1'b0;
    logic        sec_tick = 1'b0;
    logic        enable = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_reload = '0;
    logic [2:0]  cfg_sel = '0;
    logic        flag_clr = 1'b0;
    logic        wake_flag;
    logic        wake_irq;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    rtc_wakeup_timer uut (
        .clk(clk), .rst_n(rst_n), .lsclk_raw(lsclk_raw), .sec_tick(sec_tick),
        .enable(enable), .cfg_we(cfg_we), .cfg_reload(cfg_reload),
        .cfg_sel(cfg_sel), .flag_clr(flag_clr),
        .wake_flag(wake_flag), .wake_irq(wake_irq)
    );

    always @(posedge clk) if (wake_irq) irq_cnt <= irq_cnt + 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One full low-speed cycle: 4 clk high, 4 clk low
    task automatic ls_cycle();
        lsclk_raw = 1'b1; clks(4);
        lsclk_raw = 1'b0; clks(4);
    endtask

    task automatic configure(input int reload, input int sel);
        enable = 1'b0; clks(1);
        cfg_reload = 16'(reload); cfg_sel = 3'(sel); cfg_we = 1'b1; clks(1);
        cfg_we = 1'b0; clks(1);
        enable = 1'b1; clks(1);
        irq_cnt = 0;
    endtask

    initial begin
        #950000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        clks(3);
        // R1 reset state
        check("R1 flag", int'(wake_flag), 0);
        check("R1 irq", int'(wake_irq), 0);
        rst_n = 1'b1; clks(2);

        // R3 R4 R5: every divider, reload 0..5, checked after every edge
        for (int s = 0; s < 4; s++) begin
            for (int n = 0; n < 6; n++) begin
                int div;
                int per;
                div = 16 >> s;
                per = div * (n + 1);
                configure(n, s);
                for (int e = 1; e <= 2 * per + 1; e++) begin
                    ls_cycle();
                    check($sformatf("R3 R4 R5 sel%0d n%0d edge%0d", s, n, e), irq_cnt, e / per);
                end
                // R6 sticky flag, then cleared
                check("R6 flag set", int'(wake_flag), 1);
                flag_clr = 1'b1; clks(1); flag_clr = 1'b0; clks(1);
                check("R6 flag cleared", int'(wake_flag), 0);
            end
        end

        // R10 reload 0 with divide by 2
        configure(0, 3);
        for (int e = 1; e <= 8; e++) begin
            ls_cycle();
            check("R10 every two cycles", irq_cnt, e / 2);
        end

        // R2 write while enabled is ignored (period stays 6 edges)
        configure(2, 3);
        cfg_reload = 16'd0; cfg_sel = 3'd0; cfg_we = 1'b1; clks(1); cfg_we = 1'b0;
        for (int e = 1; e <= 12; e++) ls_cycle();
        check("R2 locked write", irq_cnt, 2);

        // R9 disable mid-count discards partial count
        configure(3, 3);
        for (int e = 1; e <= 5; e++) ls_cycle();
        enable = 1'b0;
        for (int e = 1; e <= 6; e++) ls_cycle();
        check("R9 no event when disabled", irq_cnt, 0);
        enable = 1'b1; clks(1);
        for (int e = 1; e <= 7; e++) ls_cycle();
        check("R9 restart edge 7", irq_cnt, 0);
        ls_cycle();
        check("R9 restart edge 8", irq_cnt, 1);

        // R7 1 Hz source, reload 3, low-speed edges ignored
        configure(3, 4);
        for (int e = 1; e <= 6; e++) ls_cycle();
        check("R7 lsclk ignored", irq_cnt, 0);
        for (int t = 1; t <= 9; t++) begin
            sec_tick = 1'b1; clks(1); sec_tick = 1'b0; clks(3);
            check($sformatf("R7 tick%0d", t), irq_cnt, t / 4);
        end
        configure(1, 5);
        for (int t = 1; t <= 4; t++) begin
            sec_tick = 1'b1; clks(1); sec_tick = 1'b0; clks(3);
        end
        check("R7 code 101", irq_cnt, 2);

        // R8 range extension: reload 0 needs 65537 ticks
        configure(0, 6);
        sec_tick = 1'b1; clks(65536); sec_tick = 1'b0; clks(3);
        check("R8 before extended expiry", irq_cnt, 0);
        sec_tick = 1'b1; clks(1); sec_tick = 1'b0; clks(3);
        check("R8 extended expiry", irq_cnt, 1);
        check("R8 flag", int'(wake_flag), 1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule